// File: doc/BRIEF.md
# Token-Conditioned Operand-Isolated ALU

This block is a cycle-level model of a 32-bit arithmetic unit in which every channel carries a value together with a token flag. Each clock cycle stands for one iteration of a handshake pipeline. A channel without its flag set carries "no token" (N). Any plain function whose input lacks a token produces no token. The unit accepts two operands and an opcode. It decodes the opcode into one select per functional unit (adder, subtractor, multiplier). The select is used to condition which units receive operand tokens and which unit outputs reach the result.

Isolation is modelled as conditional token delivery. An isolated unit receives operand tokens only in the cycles where it is selected. Its operand latches hold their previous contents in all other cycles, so its inputs do not toggle. A non-isolated unit receives operands whenever both operand channels carry tokens, whatever the opcode. The result merge forwards a unit's output only when that unit is selected. Parameters choose which units are isolated. By default only the multiplier is isolated, because it is selected rarely and is costly. The adder and subtractor are left unconditional.

Top module: `tok_alu`

## Requirements
- R1: `r_tok` is 1 in the same cycle exactly when `a_tok`, `b_tok` and `op_tok` are all 1 and `op_val` is not 2'b11.
- R2: With opcode 2'b00 and `r_tok` high, `r_val` equals `a_val + b_val` modulo 2^32.
- R3: With opcode 2'b01 and `r_tok` high, `r_val` equals `a_val - b_val` modulo 2^32.
- R4: With opcode 2'b10 and `r_tok` high, `r_val` equals the low 32 bits of `a_val * b_val`.
- R5: `op_err` is 1 exactly when `op_tok` is 1 and `op_val` is 2'b11. In that cycle `r_tok` is 0.
- R6: An isolated unit receives a token (bit k of `unit_tok`, with k = 0 adder, 1 subtractor, 2 multiplier, equal to its opcode) only when `a_tok`, `b_tok` and `op_tok` are 1 and `op_val` equals k. With default parameters this applies to bit 2.
- R7: A non-isolated unit's `unit_tok` bit is 1 whenever `a_tok` and `b_tok` are both 1, regardless of `op_tok` and `op_val`. With default parameters this applies to bits 0 and 1.
- R8: An isolated unit k exposes its operand latches on `hold_a[32k+31:32k]` and `hold_b[32k+31:32k]`. At a clock edge they load `a_val`/`b_val` only if the unit received a token in that cycle. Otherwise they keep their value. The slices of non-isolated units read zero.
- R9: After reset all operand latches read zero, and `r_val` is zero in every cycle in which `r_tok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_val | input | 32 | Operand A value |
| a_tok | input | 1 | Operand A token present |
| b_val | input | 32 | Operand B value |
| b_tok | input | 1 | Operand B token present |
| op_val | input | 2 | Opcode: 00 add, 01 subtract, 10 multiply, 11 illegal |
| op_tok | input | 1 | Opcode token present |
| r_val | output | 32 | Result value, zero when no token |
| r_tok | output | 1 | Result token present |
| op_err | output | 1 | Illegal opcode received |
| unit_tok | output | 3 | Per-unit operand token delivered this cycle |
| hold_a | output | 96 | Operand A latches, 32 bits per unit |
| hold_b | output | 96 | Operand B latches, 32 bits per unit |

## Verification
The arithmetic is exercised with carry-out and borrow edge values (all-ones plus one, zero minus one) and with a large product. These separate a correct 32-bit wrap from a widened or wrongly selected unit. Cycles with each single token missing and with the illegal opcode show whether the token AND is complete and whether the error and result paths are kept apart. Long random runs alternate multiply and non-multiply cycles with random token drops. Comparing the multiplier latches and the per-unit token flags with a model tells isolated delivery apart from unconditional delivery, and shows whether held operands leak a load on cycles where the unit is not selected.

// File: rtl/alu_tok_pkg.sv
package alu_tok_pkg;

  localparam int unsigned NUNIT = 3;
  localparam int unsigned OPW   = 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_BAD = 2'b11
  } alu_op_e;

endpackage

// File: rtl/tok_op_decode.sv
module tok_op_decode
  import alu_tok_pkg::*;
(
  input  logic [OPW-1:0]   op_val,
  input  logic             op_tok,
  output logic [NUNIT-1:0] sel,
  output logic             bad
);

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUNIT; k++) begin
      sel[k] = op_tok && (op_val == OPW'(k));
    end
    bad = op_tok && (op_val == OP_BAD);
  end

endmodule

// File: rtl/tok_fu_slot.sv
module tok_fu_slot
  import alu_tok_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned KIND = 0,
  parameter bit          ISO  = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_tok,
  input  logic         sel,
  output logic [W-1:0] res,
  output logic         res_tok,
  output logic [W-1:0] hold_a,
  output logic [W-1:0] hold_b
);

  logic         recv;
  logic [W-1:0] opx;
  logic [W-1:0] opy;

  generate
    if (ISO) begin : g_iso
      logic [W-1:0] ha_q, hb_q, ha_d, hb_d;

      // receive point gated by the decoded select
      assign recv = ab_tok && sel;

      always_comb begin
        ha_d = ha_q;
        hb_d = hb_q;
        if (recv) begin
          ha_d = a_in;
          hb_d = b_in;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ha_q <= '0;
          hb_q <= '0;
        end else if (recv) begin
          ha_q <= ha_d;
          hb_q <= hb_d;
        end
      end

      // unit inputs stay frozen on the latched values when no token arrives
      assign opx    = recv ? a_in : ha_q;
      assign opy    = recv ? b_in : hb_q;
      assign hold_a = ha_q;
      assign hold_b = hb_q;
    end else begin : g_plain
      logic unused_iso;
      assign unused_iso = &{1'b0, clk, rst_n, sel};
      assign recv   = ab_tok;
      assign opx    = a_in;
      assign opy    = b_in;
      assign hold_a = '0;
      assign hold_b = '0;
    end
  endgenerate

  generate
    if (KIND == 0) begin : g_add
      assign res = opx + opy;
    end else if (KIND == 1) begin : g_sub
      assign res = opx - opy;
    end else begin : g_mul
      assign res = opx * opy;
    end
  endgenerate

  assign res_tok = recv;

endmodule

// File: rtl/tok_result_merge.sv
module tok_result_merge
  import alu_tok_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [NUNIT*W-1:0] unit_val,
  input  logic [NUNIT-1:0]   unit_tok,
  input  logic [NUNIT-1:0]   sel,
  output logic [W-1:0]       r_val,
  output logic               r_tok
);

  logic [NUNIT-1:0] cond_tok;

  // send/receive pair on every merge input, enabled by its select
  assign cond_tok = unit_tok & sel;

  always_comb begin
    r_val = '0;
    for (int k = 0; k < NUNIT; k++) begin
      r_val = r_val | ({W{cond_tok[k]}} & unit_val[k*W +: W]);
    end
    r_tok = |cond_tok;
  end

endmodule

// File: rtl/tok_alu.sv
module tok_alu
  import alu_tok_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          ISO_ADD = 1'b0,
  parameter bit          ISO_SUB = 1'b0,
  parameter bit          ISO_MUL = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       a_val,
  input  logic               a_tok,
  input  logic [W-1:0]       b_val,
  input  logic               b_tok,
  input  logic [OPW-1:0]     op_val,
  input  logic               op_tok,
  output logic [W-1:0]       r_val,
  output logic               r_tok,
  output logic               op_err,
  output logic [NUNIT-1:0]   unit_tok,
  output logic [NUNIT*W-1:0] hold_a,
  output logic [NUNIT*W-1:0] hold_b
);

  localparam logic [NUNIT-1:0] ISO_VEC = {ISO_MUL, ISO_SUB, ISO_ADD};

  logic [NUNIT-1:0]   sel;
  logic               ab_tok;
  logic [NUNIT*W-1:0] unit_val;

  assign ab_tok = a_tok && b_tok;

  tok_op_decode u_dec (
    .op_val (op_val),
    .op_tok (op_tok),
    .sel    (sel),
    .bad    (op_err)
  );

  generate
    for (genvar k = 0; k < NUNIT; k++) begin : g_unit
      tok_fu_slot #(
        .W    (W),
        .KIND (k),
        .ISO  (ISO_VEC[k])
      ) u_fu (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (a_val),
        .b_in    (b_val),
        .ab_tok  (ab_tok),
        .sel     (sel[k]),
        .res     (unit_val[k*W +: W]),
        .res_tok (unit_tok[k]),
        .hold_a  (hold_a[k*W +: W]),
        .hold_b  (hold_b[k*W +: W])
      );
    end
  endgenerate

  tok_result_merge #(.W(W)) u_merge (
    .unit_val (unit_val),
    .unit_tok (unit_tok),
    .sel      (sel),
    .r_val    (r_val),
    .r_tok    (r_tok)
  );

endmodule

// File: rtl/tok_alu_chk.sv
module tok_alu_chk
  import alu_tok_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          ISO_ADD = 1'b0,
  parameter bit          ISO_SUB = 1'b0,
  parameter bit          ISO_MUL = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [W-1:0]       a_val,
  input logic               a_tok,
  input logic [W-1:0]       b_val,
  input logic               b_tok,
  input logic [OPW-1:0]     op_val,
  input logic               op_tok,
  input logic [W-1:0]       r_val,
  input logic               r_tok,
  input logic               op_err,
  input logic [NUNIT-1:0]   unit_tok,
  input logic [NUNIT*W-1:0] hold_a,
  input logic [NUNIT*W-1:0] hold_b
);

  localparam logic [NUNIT-1:0] ISO_VEC = {ISO_MUL, ISO_SUB, ISO_ADD};

  assert_tok_R1: assert property (@(posedge clk) disable iff (!rst_n)
    r_tok == (a_tok && b_tok && op_tok && (op_val != OP_BAD)));

  assert_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> (!r_tok && op_tok));

  assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !r_tok |-> (r_val == '0));

  generate
    for (genvar k = 0; k < NUNIT; k++) begin : g_u
      if (ISO_VEC[k]) begin : g_iso
        assert_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
          unit_tok[k] |-> (a_tok && b_tok && op_tok && (op_val == OPW'(k))));

        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
          !unit_tok[k] |=> ($stable(hold_a[k*W +: W]) && $stable(hold_b[k*W +: W])));

        assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
          unit_tok[k] |=> ((hold_a[k*W +: W] == $past(a_val)) &&
                           (hold_b[k*W +: W] == $past(b_val))));
      end else begin : g_plain
        assert_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (a_tok && b_tok) |-> unit_tok[k]);
      end
    end
  endgenerate

endmodule

bind tok_alu tok_alu_chk #(
  .W       (W),
  .ISO_ADD (ISO_ADD),
  .ISO_SUB (ISO_SUB),
  .ISO_MUL (ISO_MUL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a_val    (a_val),
  .a_tok    (a_tok),
  .b_val    (b_val),
  .b_tok    (b_tok),
  .op_val   (op_val),
  .op_tok   (op_tok),
  .r_val    (r_val),
  .r_tok    (r_tok),
  .op_err   (op_err),
  .unit_tok (unit_tok),
  .hold_a   (hold_a),
  .hold_b   (hold_b)
);

// File: tb/tok_alu_tb.sv
`timescale 1ns/1ps
module tok_alu_tb;

  localparam int W = 32;
  localparam int N = 3;
  localparam logic [N-1:0] ISO_B = 3'b100;

  logic           clk;
  logic           rst_n;
  logic [W-1:0]   a_val, b_val;
  logic           a_tok, b_tok, op_tok;
  logic [1:0]     op_val;
  logic [W-1:0]   r_val;
  logic           r_tok, op_err;
  logic [N-1:0]   unit_tok;
  logic [N*W-1:0] hold_a, hold_b;

  typedef struct {
    logic [W-1:0]   rval;
    logic           rtok;
    logic           err;
    logic [N-1:0]   utok;
    logic [N*W-1:0] ha;
    logic [N*W-1:0] hb;
    logic [1:0]     op;
  } item_t;

  item_t q[$];
  logic [N*W-1:0] m_ha, m_hb;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  tok_alu u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_val(a_val), .a_tok(a_tok), .b_val(b_val), .b_tok(b_tok),
    .op_val(op_val), .op_tok(op_tok),
    .r_val(r_val), .r_tok(r_tok), .op_err(op_err),
    .unit_tok(unit_tok), .hold_a(hold_a), .hold_b(hold_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, logic [N*W-1:0] got, logic [N*W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic at, logic bt,
                       logic [1:0] op, logic ot);
    item_t it;
    logic ab;
    @(posedge clk);
    #1;
    a_val = a; b_val = b; a_tok = at; b_tok = bt; op_val = op; op_tok = ot;
    ab = at && bt;
    it.op   = op;
    it.rtok = ab && ot && (op != 2'b11);
    it.err  = ot && (op == 2'b11);
    case (op)
      2'b00:   it.rval = a + b;
      2'b01:   it.rval = a - b;
      default: it.rval = a * b;
    endcase
    if (!it.rtok) it.rval = '0;
    for (int k = 0; k < N; k++)
      it.utok[k] = ISO_B[k] ? (ab && ot && (op == 2'(k))) : ab;
    it.ha = m_ha;
    it.hb = m_hb;
    q.push_back(it);
    for (int k = 0; k < N; k++) begin
      if (ISO_B[k] && it.utok[k]) begin
        m_ha[k*W +: W] = a;
        m_hb[k*W +: W] = b;
      end
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      string vt;
      it = q.pop_front();
      vt = !it.rtok ? "R9" : (it.op == 2'b00) ? "R2" : (it.op == 2'b01) ? "R3" : "R4";
      chk("R1", "r_tok", {95'd0, r_tok}, {95'd0, it.rtok});
      chk(vt, "r_val", {64'd0, r_val}, {64'd0, it.rval});
      chk("R5", "op_err", {95'd0, op_err}, {95'd0, it.err});
      chk("R6 R7", "unit_tok", {93'd0, unit_tok}, {93'd0, it.utok});
      chk("R8", "hold_a", hold_a, it.ha);
      chk("R8", "hold_b", hold_b, it.hb);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ha = '0; m_hb = '0;
    rst_n = 1'b0;
    a_val = '0; b_val = '0; a_tok = 1'b0; b_tok = 1'b0; op_val = 2'b00; op_tok = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // reset state: latches zero, no token, no error (R9)
    chk("R9", "reset hold_a", hold_a, '0);
    chk("R9", "reset hold_b", hold_b, '0);
    chk("R9", "reset r_tok", {95'd0, r_tok}, '0);
    chk("R9", "reset r_val", {64'd0, r_val}, '0);

    // R2 R3 R4 wrap and product edges
    drive(32'hFFFF_FFFF, 32'h1, 1, 1, 2'b00, 1);
    drive(32'h0, 32'h1, 1, 1, 2'b01, 1);
    drive(32'h1234_5678, 32'h9ABC_DEF1, 1, 1, 2'b10, 1);
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 2'b10, 1);
    // R8: non-selected multiplier keeps latches across add and sub
    drive(32'hAAAA_0000, 32'h5555, 1, 1, 2'b00, 1);
    drive(32'hDEAD_BEEF, 32'h0BAD_F00D, 1, 1, 2'b01, 1);
    // R1 missing tokens; R6 multiplier must not load; R7 add/sub still receive
    drive(32'h7, 32'h9, 0, 1, 2'b10, 1);
    drive(32'h7, 32'h9, 1, 0, 2'b10, 1);
    drive(32'h7, 32'h9, 1, 1, 2'b10, 0);
    // R5 illegal opcode, with and without opcode token
    drive(32'h3, 32'h4, 1, 1, 2'b11, 1);
    drive(32'h3, 32'h4, 1, 1, 2'b11, 0);
    drive(32'h3, 32'h4, 0, 0, 2'b11, 1);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive($urandom, $urandom, r[2:0] != 3'd0, r[5:3] != 3'd0, r[7:6], r[10:8] != 3'd0);
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule